// File: doc/BRIEF.md
# Dual Reloadable Down-Counter with Interrupt Unit

This block holds two independent down-counting timers and a small interrupt unit. Software reaches them through a 32-bit word register interface. Each timer has three registers: a reload value (the divisor), a live count that can only be read, and a control word. The control word carries an operation code (load, hold or run) and a rate select.

The block generates no clocks of its own. The rate select chooses one of four external tick-enable inputs, or no source at all. A running timer counts down once per selected tick. When it expires it reloads itself and raises its status bit. Software masks those status bits, acknowledges them by writing ones, and can read a masked view of them. A single level interrupt line is the OR of the masked status bits.

A free-running time counter is also readable. It advances by one on every clock; with the intended 100 MHz clock that is one step per 10 ns.

Top module: `dual_timer_irq`

## Requirements
- R1: Timer n (n = 0, 1) has registers at offset 0x10*n: the divisor at +0x00 (read/write, 32 bits), the live count at +0x04 (read-only, and writes to it are ignored), and the control word at +0x08 (read/write, bits [4:0] stored, upper bits read as zero).
- R2: A control write with operation field [1:0] = 0 copies the divisor into the count and leaves the timer stopped.
- R3: Operation field value 1 stops the timer, and the count then stays frozen regardless of ticks.
- R4: Operation field value 2 starts the timer. On each selected tick the count drops by one. A tick that finds the count at 1 or 0 instead reloads the divisor and signals expiry, so the period is divisor ticks.
- R5: Control bits [4:2] select the tick source: code 4 uses tick_in[0], code 5 tick_in[1], code 6 tick_in[2] and code 7 tick_in[3]. Codes 0 to 3 select no source, and a running timer then does not count.
- R6: A control write with operation field 3 is ignored: the stored control word, the count and the run state are all unchanged.
- R7: Expiry of timer 0 sets status bit 0 and expiry of timer 1 sets status bit 1. If an expiry and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R8: Offset 0x48 is the read/write mask (bits [1:0]). A write to 0x4C clears each status bit whose written bit is 1. Offset 0x54 reads status AND mask.
- R9: irq is high exactly when some status bit and its mask bit are both set. It follows a mask write, acknowledge write or expiry in the next cycle.
- R10: Offset 0x38 reads a time counter that increments by one on every clock cycle.
- R11: Reads of any other offset return zero, and writes to other offsets change no register.
- R12: Synchronous active-low reset clears all divisors, counts, control words, status, mask and the time counter, stops both timers and drives irq low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_in | input | 4 | External tick enables for rate codes 4 to 7 |
| irq | output | 1 | Level interrupt, OR of masked status |

## Verification
The bench aims at the reload boundary. A count of 1 must reload and expire, so a design that decrements to zero first would show a period one tick too long. It also confirms that ticks on a source other than the selected one do nothing, so a wrong rate decode would count on foreign ticks. It aims an acknowledge at the very cycle an expiry arrives, where a design that let the clear win would lose an interrupt. It also checks that an illegal operation code and writes to the read-only count or unmapped offsets leave every register untouched, since a careless decode would corrupt the control word or the count.

// File: rtl/dtmr_pkg.sv
// Shared constants and types for the dual timer block.
// Assumes byte offsets and a 32-bit word interface.
package dtmr_pkg;
    localparam int N_TMR      = 2;
    localparam int CTRL_W     = 5;
    localparam int N_SRC      = 4;
    localparam int TMR_STRIDE = 'h10;
    localparam int OFF_DIV    = 'h00;
    localparam int OFF_CNT    = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_TIME   = 'h38;
    localparam int OFF_MASK   = 'h48;
    localparam int OFF_ACK    = 'h4C;
    localparam int OFF_MSTAT  = 'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;
endpackage

// File: rtl/dtmr_counter.sv
// One reloadable down-counter. It holds the divisor, the control word and the
// run state, and counts on the tick input chosen by control bits [4:2].
// Assumes ctrl_we and div_we are never set in the same cycle.
module dtmr_counter
    import dtmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_SRC-1:0]  tick_src,
    output logic [CNT_W-1:0]  div_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              run_q,
    output logic              expire
);
    logic       ctrl_take;
    logic [2:0] rate;
    logic       tick_sel;
    logic       step;

    assign ctrl_take = ctrl_we && (tmr_op_e'(wdata[1:0]) != OP_BAD);
    assign rate      = ctrl_q[4:2];
    assign tick_sel  = rate[2] && tick_src[rate[1:0]];
    assign step      = run_q && tick_sel && !ctrl_take;
    assign expire    = step && (count_q <= CNT_W'(1));

    // Divisor register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_we) div_q <= wdata[CNT_W-1:0];
    end

    // Control word, run state and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            run_q   <= 1'b0;
            count_q <= '0;
        end else if (ctrl_take) begin
            ctrl_q <= wdata[CTRL_W-1:0];
            case (tmr_op_e'(wdata[1:0]))
                OP_LOAD: begin
                    count_q <= div_q;
                    run_q   <= 1'b0;
                end
                OP_HOLD: run_q <= 1'b0;
                default: run_q <= 1'b1;
            endcase
        end else if (step) begin
            count_q <= expire ? div_q : count_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/dtmr_irq_unit.sv
// Interrupt status, mask and acknowledge logic shared by the timers.
// Assumes expire pulses last one cycle; a same-cycle expiry beats the clear.
module dtmr_irq_unit
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_TMR-1:0]  expire,
    output logic [N_TMR-1:0]  status_q,
    output logic [N_TMR-1:0]  mask_q,
    output logic              irq
);
    logic [N_TMR-1:0] clr;

    assign clr = ack_we ? wdata[N_TMR-1:0] : '0;

    // Status bits: clear on acknowledge, set on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | expire;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata[N_TMR-1:0];
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/dual_timer_irq.sv
// Top of the dual timer: address decode, read multiplexer, time counter,
// two counter instances and the interrupt unit.
// Assumes one clock of 100 MHz so that the time counter steps every 10 ns.
module dual_timer_irq
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_SRC-1:0]  tick_in,
    output logic              irq
);
    logic [N_TMR-1:0][CNT_W-1:0]  div_w;
    logic [N_TMR-1:0][CNT_W-1:0]  count_w;
    logic [N_TMR-1:0][CTRL_W-1:0] ctrl_w;
    logic [N_TMR-1:0]             run_w;
    logic [N_TMR-1:0]             expire_w;
    logic [N_TMR-1:0]             status_w;
    logic [N_TMR-1:0]             mask_w;
    logic [TIME_W-1:0]            time_q;
    logic                         mask_we;
    logic                         ack_we;

    assign mask_we = wr_en && (addr == ADDR_W'(OFF_MASK));
    assign ack_we  = wr_en && (addr == ADDR_W'(OFF_ACK));

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        localparam int BASE = g * TMR_STRIDE;
        logic div_we;
        logic ctrl_we;
        assign div_we  = wr_en && (addr == ADDR_W'(BASE + OFF_DIV));
        assign ctrl_we = wr_en && (addr == ADDR_W'(BASE + OFF_CTRL));

        dtmr_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_we   (div_we),
            .ctrl_we  (ctrl_we),
            .wdata    (wdata),
            .tick_src (tick_in),
            .div_q    (div_w[g]),
            .count_q  (count_w[g]),
            .ctrl_q   (ctrl_w[g]),
            .run_q    (run_w[g]),
            .expire   (expire_w[g])
        );
    end

    dtmr_irq_unit #(.DATA_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (mask_we),
        .ack_we   (ack_we),
        .wdata    (wdata),
        .expire   (expire_w),
        .status_q (status_w),
        .mask_q   (mask_w),
        .irq      (irq)
    );

    // Free-running time counter, one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + TIME_W'(1);
    end

    // Read multiplexer; unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_DIV))  rdata = DATA_W'(div_w[i]);
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_CNT))  rdata = DATA_W'(count_w[i]);
            if (addr == ADDR_W'(i * TMR_STRIDE + OFF_CTRL)) rdata = DATA_W'(ctrl_w[i]);
        end
        if (addr == ADDR_W'(OFF_TIME))  rdata = DATA_W'(time_q);
        if (addr == ADDR_W'(OFF_MASK))  rdata = DATA_W'(mask_w);
        if (addr == ADDR_W'(OFF_MSTAT)) rdata = DATA_W'(status_w & mask_w);
    end
endmodule

// File: rtl/dtmr_checker.sv
// Property checker for the dual timer, attached to the top through bind.
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int TIME_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic                         irq,
    input logic [N_TMR-1:0][CNT_W-1:0]  div_w,
    input logic [N_TMR-1:0][CNT_W-1:0]  count_w,
    input logic [N_TMR-1:0][CTRL_W-1:0] ctrl_w,
    input logic [N_TMR-1:0]             run_w,
    input logic [N_TMR-1:0]             expire_w,
    input logic [N_TMR-1:0]             status_w,
    input logic [TIME_W-1:0]            time_q
);
    logic wr_ctrl0;
    logic wr_ack;
    logic wr_mask;
    assign wr_ctrl0 = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign wr_ack   = wr_en && (addr == ADDR_W'(OFF_ACK));
    assign wr_mask  = wr_en && (addr == ADDR_W'(OFF_MASK));

    AST_LOAD_COPIES_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl0 && wdata[1:0] == 2'd0 |=> count_w[0] == $past(div_w[0])); // R2
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w[0] && !wr_ctrl0 |=> $stable(count_w[0])); // R3
    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl0 && wdata[1:0] == 2'd3 |=> $stable(ctrl_w[0])); // R6
    AST_EXPIRE_SETS_0: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w[0] |=> status_w[0]); // R7
    AST_EXPIRE_SETS_1: assert property (@(posedge clk) disable iff (!rst_n)
        expire_w[1] |=> status_w[1]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && wdata[0] && !expire_w[0] |=> !status_w[0]); // R8
    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask && wdata[1:0] == 2'd0 |=> !irq); // R9
    AST_TIME_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> time_q == $past(time_q) + TIME_W'(1)); // R10
endmodule

bind dual_timer_irq dtmr_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TIME_W(TIME_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .div_w    (div_w),
    .count_w  (count_w),
    .ctrl_w   (ctrl_w),
    .run_w    (run_w),
    .expire_w (expire_w),
    .status_w (status_w),
    .time_q   (time_q)
);

// File: tb/dual_timer_irq_test.sv
module dual_timer_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  tick_in = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_timer_irq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 read and compare, 2 tick pulse
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 8'h00, 32'd5,    32'd0,    8'd1},  // R1 divisor 0 = 5
        '{2'd1, 8'h00, 32'd0,    32'd5,    8'd1},  // R1 divisor readback
        '{2'd0, 8'h08, 32'h14,   32'd0,    8'd2},  // R2 load, rate 5
        '{2'd1, 8'h04, 32'd0,    32'd5,    8'd2},  // R2 count = divisor
        '{2'd1, 8'h08, 32'd0,    32'h14,   8'd1},  // R1 control readback
        '{2'd2, 8'h00, 32'h2,    32'd0,    8'd2},  // R2 stopped after load
        '{2'd1, 8'h04, 32'd0,    32'd5,    8'd2},
        '{2'd0, 8'h08, 32'h16,   32'd0,    8'd4},  // R4 run
        '{2'd2, 8'h00, 32'h2,    32'd0,    8'd4},
        '{2'd1, 8'h04, 32'd0,    32'd4,    8'd4},  // R4 one step down
        '{2'd2, 8'h00, 32'hD,    32'd0,    8'd5},  // R5 foreign ticks
        '{2'd1, 8'h04, 32'd0,    32'd4,    8'd5},
        '{2'd0, 8'h08, 32'h15,   32'd0,    8'd3},  // R3 hold
        '{2'd2, 8'h00, 32'h2,    32'd0,    8'd3},
        '{2'd1, 8'h04, 32'd0,    32'd4,    8'd3},
        '{2'd0, 8'h08, 32'h17,   32'd0,    8'd6},  // R6 bad op
        '{2'd1, 8'h08, 32'd0,    32'h15,   8'd6},
        '{2'd0, 8'h04, 32'h99,   32'd0,    8'd1},  // R1 count is read-only
        '{2'd1, 8'h04, 32'd0,    32'd4,    8'd1},
        '{2'd1, 8'h44, 32'd0,    32'd0,    8'd11}  // R11 unmapped read
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(input logic [3:0] m);
        @(negedge clk);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(8'h04, v); check(v, 0, "R12 count0");
        rd(8'h14, v); check(v, 0, "R12 count1");
        rd(8'h48, v); check(v, 0, "R12 mask");
        rd(8'h54, v); check(v, 0, "R12 masked status");
        check({31'd0, irq}, 0, "R12 irq");

        // R10 time counter steps once per clock
        rd(8'h38, t0);
        repeat (3) @(negedge clk);
        #1 check(rdata, t0 + 3, "R10 time step");

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].kind)
                2'd0: wr(VEC[i].addr, VEC[i].data);
                2'd1: begin
                    rd(VEC[i].addr, v);
                    check(v, VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i));
                end
                default: tick(VEC[i].data[3:0]);
            endcase
        end

        // R11 write to unmapped offset leaves mask alone
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h48, v); check(v, 0, "R11 unmapped write");

        // R4 R7 R9 timer 1 expiry, rate 4
        wr(8'h10, 32'd2);
        wr(8'h18, 32'h10);
        wr(8'h18, 32'h12);
        wr(8'h48, 32'h2);
        tick(4'h1);
        rd(8'h14, v); check(v, 1, "R4 count1 after one tick");
        check({31'd0, irq}, 0, "R9 irq before expiry");
        tick(4'h1);
        rd(8'h14, v); check(v, 2, "R4 reload at count 1");
        rd(8'h54, v); check(v, 2, "R7 status bit 1");
        check({31'd0, irq}, 1, "R9 irq after expiry");
        wr(8'h48, 32'h0);
        check({31'd0, irq}, 0, "R9 irq masked off");
        rd(8'h54, v); check(v, 0, "R8 masked view zero");
        wr(8'h48, 32'h3);
        check({31'd0, irq}, 1, "R9 irq unmasked");
        rd(8'h48, v); check(v, 3, "R8 mask readback");
        wr(8'h4C, 32'h2);
        check({31'd0, irq}, 0, "R8 ack drops irq");
        rd(8'h54, v); check(v, 0, "R8 ack clears status");

        // R7 expiry and acknowledge in the same cycle
        tick(4'h1);
        @(negedge clk);
        tick_in = 4'h1; wr_en = 1'b1; addr = 8'h4C; wdata = 32'h2;
        @(negedge clk);
        tick_in = '0; wr_en = 1'b0;
        rd(8'h54, v); check(v, 2, "R7 expiry beats ack");
        check({31'd0, irq}, 1, "R7 irq held");

        // R5 rate codes 0..3 do not count
        wr(8'h18, 32'h02);
        tick(4'hF);
        rd(8'h14, v); check(v, 2, "R5 rate 0 frozen");
        wr(8'h18, 32'h0E);
        tick(4'hF);
        rd(8'h14, v); check(v, 2, "R5 rate 3 frozen");

        // R12 reset in mid-operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({31'd0, irq}, 0, "R12 irq after reset");
        rd(8'h10, v); check(v, 0, "R12 divisor1");
        rd(8'h14, v); check(v, 0, "R12 count1 cleared");
        rd(8'h48, v); check(v, 0, "R12 mask cleared");
        rd(8'h38, v); check(v, 0, "R12 time cleared");
        @(negedge clk);
        rst_n = 1'b1;
        finish_run();
    end
endmodule